// File: doc/BRIEF.md
# Serial Receive Holding Buffer

This block sits between a serial frame deserializer and the register interface of a serial receiver. The deserializer raises a one-cycle strobe for each completed frame, with up to nine data bits, a stop/symbol error flag, a parity error flag and a response-space indicator. The block keeps two such frames in arrival order. It also has a staging slot that models a finished frame still held in the shift register. When the two-entry buffer is full, a new frame waits in the staging slot. If one more frame then arrives, it overwrites the staged frame and is marked as an overflow.

Two byte-wide read views always show the oldest stored frame: a low byte with data bits 7..0, and a high byte with status flags and the ninth data bit. A read strobe on one of the two views pops the frame. The view that pops depends on the character size and byte-order settings, so software reads the other view first and can fetch both bytes of one frame before the buffer advances.

Top module: `serrx_holdbuf`

## Requirements
- R1: After reset, and at any time the buffer holds no frame, both `lo_byte` and `hi_byte` read 0x00.
- R2: `lo_byte` shows data bits 7..0 of the oldest stored frame, and frames come out in the order they arrived.
- R3: For a stored frame, `hi_byte` has bit 5 = overflow, bit 4 = frame error, bit 3 = parity error, bit 2 = 1 (receive complete) and bit 0 = ninth bit. Bits 7, 6 and 1 read 0.
- R4: When `cfg_nine`=1 and `cfg_lowfirst`=1, a `rd_hi` strobe pops the buffer and `rd_lo` has no effect. In every other setting, `rd_lo` pops the buffer and `rd_hi` has no effect.
- R5: A read strobe while the buffer is empty changes nothing.
- R6: Three frames that arrive with no read between them are all kept: two in the buffer and one in the staging slot. They are delivered in order.
- R7: A frame that arrives while both entries and the staging slot are occupied replaces the staged frame and carries overflow = 1. The two older frames keep overflow = 0.
- R8: A frame that arrives in the same cycle as a pop of a full buffer with an occupied staging slot is kept without overflow. The staged frame moves into the buffer in that same cycle.
- R9: When LIN client mode is off, bit 0 of `hi_byte` is the received data bit 8 if `cfg_nine`=1, and 0 otherwise.
- R10: When `cfg_lin`=1, bit 0 of `hi_byte` is the frame's `in_resp` value: 1 for the response space, 0 for the protected identifier.
- R11: A frame received while `cfg_par_en`=0 shows a parity error flag of 0.
- R12: While `cfg_spihost`=1, bits 5 and 4 of `hi_byte` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nine | input | 1 | 9-bit character size |
| cfg_lowfirst | input | 1 | In 9-bit mode, low byte is read first |
| cfg_lin | input | 1 | LIN client frame mode |
| cfg_spihost | input | 1 | SPI host mode (hides overflow and frame error) |
| cfg_par_en | input | 1 | Parity checking enabled |
| in_valid | input | 1 | Frame completed strobe from deserializer |
| in_data | input | 9 | Received data bits |
| in_ferr | input | 1 | Stop bit / symbol error of the frame |
| in_perr | input | 1 | Parity error of the frame |
| in_resp | input | 1 | Frame lies in the LIN response space |
| rd_lo | input | 1 | Read strobe on the low byte view |
| rd_hi | input | 1 | Read strobe on the high byte view |
| lo_byte | output | 8 | Low data byte of the oldest frame |
| hi_byte | output | 8 | Status and ninth bit of the oldest frame |

## Verification
The bench sweeps all 32 combinations of the five mode inputs. For each one it sends bursts of one to four frames before draining. The one-frame and two-frame bursts check plain ordering. The three-frame burst exercises the staging slot. The four-frame burst exercises overflow replacement. Frame data and flags change with every frame, which separates the correct per-mode selection of the ninth bit, parity masking and SPI host masking from a fixed wiring. Reading the non-popping view first, striking reads on an empty buffer, and a push coinciding with a pop of a fully occupied buffer separate the pop selection, the underflow guard and the same-cycle staging move.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int DATA_W = 9;

    typedef struct packed {
        logic              ovf;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam int FRAME_W = $bits(frame_t);

    // High-byte bit positions
    localparam int HB_OVF  = 5;
    localparam int HB_FERR = 4;
    localparam int HB_PERR = 3;
    localparam int HB_RXC  = 2;
    localparam int HB_D8   = 0;

    function automatic logic ninth_bit(input logic nine, input logic lin,
                                       input logic d8, input logic resp);
        if (lin)
            return resp;
        return nine & d8;
    endfunction

    function automatic logic pop_on_high(input logic nine, input logic lowfirst);
        return nine & lowfirst;
    endfunction

endpackage

// File: rtl/serrx_frame_fmt.sv
module serrx_frame_fmt
    import serrx_pkg::*;
(
    input  logic              nine,
    input  logic              lin,
    input  logic              par_en,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              raw_ferr,
    input  logic              raw_perr,
    input  logic              raw_resp,
    output frame_t            frm
);
    always_comb begin
        frm                 = '0;
        frm.data[DATA_W-2:0] = raw_data[DATA_W-2:0];
        frm.data[DATA_W-1]   = ninth_bit(nine, lin, raw_data[DATA_W-1], raw_resp);
        frm.ferr            = raw_ferr;
        frm.perr            = raw_perr & par_en;
        frm.ovf             = 1'b0;
    end
endmodule

// File: rtl/serrx_queue.sv
module serrx_queue
    import serrx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  frame_t push_frm,
    input  logic   pop,
    output frame_t head,
    output logic   head_valid
);
    localparam int CW = $clog2(DEPTH + 1);

    frame_t         q     [DEPTH];
    frame_t         nq    [DEPTH];
    logic [CW-1:0]  cnt, ncnt;
    frame_t         stg, nstg;
    logic           stg_v, nstg_v;

    always_comb begin
        nq     = q;
        ncnt   = cnt;
        nstg   = stg;
        nstg_v = stg_v;
        // retire the oldest entry
        if (pop && cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++)
                nq[i] = q[i + 1];
            nq[DEPTH-1] = '0;
            ncnt        = cnt - 1'b1;
        end
        // a staged frame moves in as soon as a slot is free
        if (nstg_v && ncnt < CW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == ncnt) nq[i] = stg;
            ncnt   = ncnt + 1'b1;
            nstg_v = 1'b0;
        end
        // accept the new frame
        if (push) begin
            if (ncnt < CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == ncnt) nq[i] = push_frm;
                ncnt = ncnt + 1'b1;
            end else begin
                nstg     = push_frm;
                nstg.ovf = nstg_v;
                nstg_v   = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) q[g] <= '0;
            else     q[g] <= nq[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            stg   <= '0;
            stg_v <= 1'b0;
        end else begin
            cnt   <= ncnt;
            stg   <= nstg;
            stg_v <= nstg_v;
        end
    end

    assign head       = q[0];
    assign head_valid = (cnt != '0);

    // R6
    stage_full_chk: assert property (@(posedge clk) disable iff (rst)
        stg_v |-> cnt == CW'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && stg_v) |=> (stg_v && stg.ovf));

    // R8
    push_pop_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && stg_v) |=> (stg_v && !stg.ovf && cnt == CW'(DEPTH)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !push && !stg_v) |=> (cnt == '0));
endmodule

// File: rtl/serrx_port_map.sv
module serrx_port_map
    import serrx_pkg::*;
(
    input  logic       nine,
    input  logic       lowfirst,
    input  logic       spihost,
    input  logic       rd_lo,
    input  logic       rd_hi,
    input  frame_t     head,
    input  logic       head_valid,
    output logic       pop,
    output logic [7:0] lo_byte,
    output logic [7:0] hi_byte
);
    logic adv_hi;

    assign adv_hi = pop_on_high(nine, lowfirst);
    assign pop    = head_valid & (adv_hi ? rd_hi : rd_lo);

    always_comb begin
        lo_byte = 8'h00;
        hi_byte = 8'h00;
        if (head_valid) begin
            lo_byte          = head.data[7:0];
            hi_byte[HB_OVF]  = head.ovf  & ~spihost;
            hi_byte[HB_FERR] = head.ferr & ~spihost;
            hi_byte[HB_PERR] = head.perr;
            hi_byte[HB_RXC]  = 1'b1;
            hi_byte[HB_D8]   = head.data[DATA_W-1];
        end
    end
endmodule

// File: rtl/serrx_holdbuf.sv
module serrx_holdbuf
    import serrx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_nine,
    input  logic       cfg_lowfirst,
    input  logic       cfg_lin,
    input  logic       cfg_spihost,
    input  logic       cfg_par_en,
    input  logic       in_valid,
    input  logic [8:0] in_data,
    input  logic       in_ferr,
    input  logic       in_perr,
    input  logic       in_resp,
    input  logic       rd_lo,
    input  logic       rd_hi,
    output logic [7:0] lo_byte,
    output logic [7:0] hi_byte
);
    frame_t new_frm;
    frame_t head;
    logic   head_valid;
    logic   pop;

    serrx_frame_fmt u_fmt (
        .nine     (cfg_nine),
        .lin      (cfg_lin),
        .par_en   (cfg_par_en),
        .raw_data (in_data),
        .raw_ferr (in_ferr),
        .raw_perr (in_perr),
        .raw_resp (in_resp),
        .frm      (new_frm)
    );

    serrx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (in_valid),
        .push_frm   (new_frm),
        .pop        (pop),
        .head       (head),
        .head_valid (head_valid)
    );

    serrx_port_map u_map (
        .nine       (cfg_nine),
        .lowfirst   (cfg_lowfirst),
        .spihost    (cfg_spihost),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi),
        .head       (head),
        .head_valid (head_valid),
        .pop        (pop),
        .lo_byte    (lo_byte),
        .hi_byte    (hi_byte)
    );

    // R1
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !head_valid |-> (lo_byte == 8'h00 && hi_byte == 8'h00));

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_byte[7:6] == 2'b00 && hi_byte[1] == 1'b0));

    // R12
    spi_mask_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_spihost |-> hi_byte[5:4] == 2'b00);

    // R4
    wrong_view_chk: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !in_valid &&
         ((cfg_nine && cfg_lowfirst) ? (rd_lo && !rd_hi) : (rd_hi && !rd_lo)))
        |=> $stable(lo_byte) && $stable(hi_byte));
endmodule

// File: tb/serrx_holdbuf_test.sv
module serrx_holdbuf_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_nine = 0, cfg_lowfirst = 0, cfg_lin = 0, cfg_spihost = 0, cfg_par_en = 0;
    logic in_valid = 0;
    logic [8:0] in_data = '0;
    logic in_ferr = 0, in_perr = 0, in_resp = 0;
    logic rd_lo = 0, rd_hi = 0;
    logic [7:0] lo_byte, hi_byte;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench model: up to two buffered frames plus one staged
    logic [7:0] m_lo [3];
    logic       m_b8 [3];
    logic       m_fe [3];
    logic       m_pe [3];
    logic       m_ov [3];
    int         m_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serrx_holdbuf uut (
        .clk(clk), .rst(rst),
        .cfg_nine(cfg_nine), .cfg_lowfirst(cfg_lowfirst), .cfg_lin(cfg_lin),
        .cfg_spihost(cfg_spihost), .cfg_par_en(cfg_par_en),
        .in_valid(in_valid), .in_data(in_data), .in_ferr(in_ferr),
        .in_perr(in_perr), .in_resp(in_resp),
        .rd_lo(rd_lo), .rd_hi(rd_hi),
        .lo_byte(lo_byte), .hi_byte(hi_byte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_hi();
        return {2'b00, m_ov[0] & ~cfg_spihost, m_fe[0] & ~cfg_spihost,
                m_pe[0], 1'b1, 1'b0, m_b8[0]};
    endfunction

    task automatic model_pop();
        for (int i = 0; i < 2; i++) begin
            m_lo[i] = m_lo[i+1]; m_b8[i] = m_b8[i+1];
            m_fe[i] = m_fe[i+1]; m_pe[i] = m_pe[i+1]; m_ov[i] = m_ov[i+1];
        end
        m_n--;
    endtask

    task automatic model_push(input logic [8:0] d, input logic fe, input logic pe,
                              input logic rs);
        int slot;
        logic ov;
        ov   = (m_n == 3);
        slot = ov ? 2 : m_n;
        m_lo[slot] = d[7:0];
        m_b8[slot] = cfg_lin ? rs : (cfg_nine & d[8]);
        m_fe[slot] = fe;
        m_pe[slot] = pe & cfg_par_en;
        m_ov[slot] = ov;
        if (!ov) m_n++;
    endtask

    // called just after a falling edge; returns after the next one
    task automatic push(input logic [8:0] d, input logic fe, input logic pe,
                        input logic rs, input logic with_pop);
        in_valid = 1; in_data = d; in_ferr = fe; in_perr = pe; in_resp = rs;
        if (with_pop) begin
            if (cfg_nine && cfg_lowfirst) rd_hi = 1; else rd_lo = 1;
        end
        @(negedge clk);
        in_valid = 0; rd_lo = 0; rd_hi = 0;
        if (with_pop) model_pop();
        model_push(d, fe, pe, rs);
    endtask

    task automatic read_frame(input string tag);
        logic [7:0] lo0, hi0;
        logic adv_hi;
        adv_hi = cfg_nine & cfg_lowfirst;
        chk(tag, lo_byte, m_lo[0]);
        chk("R3", hi_byte, exp_hi());
        if (cfg_lin) chk("R10", {7'd0, hi_byte[0]}, {7'd0, m_b8[0]});
        else         chk("R9",  {7'd0, hi_byte[0]}, {7'd0, m_b8[0]});
        if (!cfg_par_en) chk("R11", {7'd0, hi_byte[3]}, 8'd0);
        if (cfg_spihost) chk("R12", {6'd0, hi_byte[5:4]}, 8'd0);
        else             chk("R7",  {7'd0, hi_byte[5]}, {7'd0, m_ov[0]});
        lo0 = lo_byte; hi0 = hi_byte;
        // non-advancing view first
        if (adv_hi) rd_lo = 1; else rd_hi = 1;
        @(negedge clk);
        rd_lo = 0; rd_hi = 0;
        chk("R4", lo_byte, lo0);
        chk("R4", hi_byte, hi0);
        // advancing view
        if (adv_hi) rd_hi = 1; else rd_lo = 1;
        @(negedge clk);
        rd_lo = 0; rd_hi = 0;
        model_pop();
    endtask

    task automatic check_empty();
        chk("R1", lo_byte, 8'h00);
        chk("R1", hi_byte, 8'h00);
        rd_lo = 1; rd_hi = 1;
        @(negedge clk);
        rd_lo = 0; rd_hi = 0;
        @(negedge clk);
        chk("R5", lo_byte, 8'h00);
        chk("R5", hi_byte, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", lo_byte, 8'h00);
        chk("R1", hi_byte, 8'h00);

        for (int c = 0; c < 32; c++) begin
            cfg_nine = c[0]; cfg_lowfirst = c[1]; cfg_lin = c[2];
            cfg_spihost = c[3]; cfg_par_en = c[4];
            for (int n = 1; n <= 4; n++) begin
                for (int k = 0; k < n; k++) begin
                    logic [8:0] d;
                    d = 9'((c * 37 + n * 11 + k * 71 + 5) & 9'h1ff);
                    if (k[0]) d[8] = ~d[8];
                    push(d, k[0] ^ n[0], ((k + c) % 3) == 0, k[1] ^ c[0], 1'b0);
                end
                while (m_n > 0) read_frame(n >= 4 ? "R7" : (n == 3 ? "R6" : "R2"));
                check_empty();
            end
            // push coinciding with pop of a full buffer and occupied staging slot
            for (int k = 0; k < 3; k++)
                push(9'((c * 13 + k * 29) & 9'h1ff), k[0], k[1], k[0], 1'b0);
            push(9'((c * 7 + 200) & 9'h1ff), 1'b1, 1'b1, 1'b1, 1'b1);
            while (m_n > 0) read_frame("R8");
            check_empty();
        end
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule